// File: doc/BRIEF.md
# Latched-Address Byte-Lane SRAM

This block is an 18-bit-wide word memory split into two 9-bit byte lanes. Three sets of input holding registers sit in front of the array. The first holds the address. The second holds the chip select. The third holds the write data. Two latch-enable inputs control these registers. While its enable is high, a holding register follows its input every clock. While its enable is low, it keeps the value it had when the enable went low. If both enables are kept high, the block works as a plain synchronous single-port SRAM.

The two write strobes and the output enable are active low, and they are registered on every cycle. Array access happens one clock after the inputs are captured, and it uses the captured values. Each lane can be written on its own, or both lanes together. Read data goes out on a data bus with a valid flag, which stands in for a tri-state pin. The bus reads zero whenever the outputs are off. The outputs are off when the block is deselected, when the output enable is high, and during any write.

The array depth is a parameter with a default of 256 words. The address width is derived from the depth. Full-size use would set a depth of 65,536 words, which gives 16 address bits.

Top module: `lat_sram`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rd_valid` is 0 and `rd_data` is 0. After reset the captured chip select is inactive (high) and the captured strobes are inactive.
- R2: On a clock where `addr_le` is 1, the address and chip-select holding registers load `addr_in` and `sel_n`. Where `addr_le` is 0, they keep their value, so later changes on `addr_in`/`sel_n` have no effect.
- R3: On a clock where `data_le` is 1, the write-data register loads `wr_data`. Where it is 0, the register keeps its value, and a later write stores that held value.
- R4: With `addr_le` and `data_le` both tied to 1, the block acts as an unlatched synchronous SRAM. A read presented at clock edge k shows its data after edge k+1.
- R5: The captured `wr_lo_n` = 0 writes bits 8:0 and the captured `wr_hi_n` = 0 writes bits 17:9. The lane whose strobe is high keeps its old contents.
- R6: When both strobes are low in one captured cycle, both lanes are written with the full 18-bit word.
- R7: When the captured chip select is high, no lane is written and the outputs stay off, whatever the strobes and output enable do.
- R8: With the captured chip select low, both captured strobes high and the captured `out_en_n` low, the next clock sets `rd_valid` = 1, and `rd_data` holds the word stored at the captured address.
- R9: When the captured `out_en_n` is high and no write is in progress, the outputs stay off.
- R10: During a captured write cycle (selected, either strobe low), the outputs are off even if `out_en_n` is low.
- R11: Whenever `rd_valid` is 0, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_le | input | 1 | Address/chip-select capture enable (1 = follow, 0 = hold) |
| data_le | input | 1 | Write-data capture enable (1 = follow, 0 = hold) |
| addr_in | input | AW (8) | Word address |
| sel_n | input | 1 | Chip select, active low |
| wr_lo_n | input | 1 | Lower lane (bits 8:0) write strobe, active low |
| wr_hi_n | input | 1 | Upper lane (bits 17:9) write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_data | input | 18 | Write data |
| rd_data | output | 18 | Read data, zero while outputs are off |
| rd_valid | output | 1 | Outputs driven (stands in for a non-high-impedance bus) |

## Verification
The hardest case to reach is one where the array is accessed at a held address or with held data, while the live address, select and data inputs already show different values. Only a model of what was captured can tell a correct hold from a wrong follow. The stimulus loads an address or data word with its enable high, then drops the enable and scrambles the live inputs during the following reads and writes. A long random phase toggles both enables independently, so holds and captures interleave with partial-lane writes and deselected cycles.

// File: rtl/lat_sram_pkg.sv
package lat_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef struct packed {
        logic sel_n;
        logic wr_hi_n;
        logic wr_lo_n;
        logic oe_n;
    } ctrl_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;

    localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b1, wr_hi_n: 1'b1, wr_lo_n: 1'b1, oe_n: 1'b1};

    function automatic op_t decode_op(input ctrl_t c);
        op_t o;
        if (c.sel_n)
            o = OP_IDLE;
        else if (!c.wr_lo_n || !c.wr_hi_n)
            o = OP_WRITE;
        else if (!c.oe_n)
            o = OP_READ;
        else
            o = OP_IDLE;
        return o;
    endfunction

    function automatic logic [LANES-1:0] lane_strobes(input ctrl_t c);
        logic [LANES-1:0] s;
        s[0] = !c.sel_n && !c.wr_lo_n;
        s[1] = !c.sel_n && !c.wr_hi_n;
        return s;
    endfunction

endpackage

// File: rtl/lat_sram_hold.sv
module lat_sram_hold #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (en)
            q <= d;
    end

    // R2 / R3: follow while enabled
    a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
        en |=> q == $past(d));

    // R2 / R3: hold while disabled
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/lat_sram_array.sv
module lat_sram_array
    import lat_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rword
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[l])
                lane_mem[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rword[l*LANE_W +: LANE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/lat_sram_rdport.sv
module lat_sram_rdport
    import lat_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (op == OP_READ) begin
            rd_data  <= word;
            rd_valid <= 1'b1;
        end else begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end
    end

    // R11: bus quiet whenever outputs are off
    a_r11_off_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);

endmodule

// File: rtl/lat_sram.sv
module lat_sram
    import lat_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_le,
    input  logic              data_le,
    input  logic [AW-1:0]     addr_in,
    input  logic              sel_n,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [AW-1:0]     addr_q;
    logic              sel_q;
    logic [WORD_W-1:0] data_q;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_live;
    op_t               op;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] word;

    lat_sram_hold #(.W(AW), .RST_VAL('0)) u_addr_hold (
        .clk(clk), .rst(rst), .en(addr_le), .d(addr_in), .q(addr_q)
    );

    lat_sram_hold #(.W(1), .RST_VAL(1'b1)) u_sel_hold (
        .clk(clk), .rst(rst), .en(addr_le), .d(sel_n), .q(sel_q)
    );

    lat_sram_hold #(.W(WORD_W), .RST_VAL('0)) u_data_hold (
        .clk(clk), .rst(rst), .en(data_le), .d(wr_data), .q(data_q)
    );

    // strobes and output enable are captured every cycle
    always_comb begin
        ctrl_live         = CTRL_IDLE;
        ctrl_live.wr_lo_n = wr_lo_n;
        ctrl_live.wr_hi_n = wr_hi_n;
        ctrl_live.oe_n    = out_en_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_IDLE;
        else
            ctrl_q <= ctrl_live;
    end

    ctrl_t ctrl_eff;
    always_comb begin
        ctrl_eff       = ctrl_q;
        ctrl_eff.sel_n = sel_q;
    end

    assign op      = decode_op(ctrl_eff);
    assign lane_we = lane_strobes(ctrl_eff);

    lat_sram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .lane_we(lane_we), .addr(addr_q), .wdata(data_q), .rword(word)
    );

    lat_sram_rdport u_rdport (
        .clk(clk), .rst(rst), .op(op), .word(word),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R1: outputs off right after reset
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> !rd_valid && rd_data == '0);

    // R7: deselected cycle never drives
    a_r7_desel_off: assert property (@(posedge clk) disable iff (rst)
        sel_q |=> !rd_valid);

    // R7: deselected cycle never enables a lane
    a_r7_desel_nowrite: assert property (@(posedge clk) disable iff (rst)
        sel_q |-> lane_we == '0);

    // R9: output enable high keeps the bus off
    a_r9_oe_off: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.oe_n |=> !rd_valid);

    // R10: any write keeps the bus off
    a_r10_write_off: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && (!ctrl_q.wr_lo_n || !ctrl_q.wr_hi_n)) |=> !rd_valid);

    // R8: a selected read with output enable drives the bus
    a_r8_read_on: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && ctrl_q.wr_lo_n && ctrl_q.wr_hi_n && !ctrl_q.oe_n) |=> rd_valid);

endmodule

// File: tb/lat_sram_test.sv
module lat_sram_test;

    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_le = 1'b1;
    logic          data_le = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          sel_n = 1'b1;
    logic          wr_lo_n = 1'b1;
    logic          wr_hi_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;

    always #2.5 clk = ~clk;

    lat_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .addr_le(addr_le), .data_le(data_le),
        .addr_in(addr_in), .sel_n(sel_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
        .out_en_n(out_en_n), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // behavioural reference
    logic [W-1:0]  ref_mem [DEPTH];
    int            m_addr;
    bit            m_sel_n, m_wl_n, m_wh_n, m_oe_n;
    logic [W-1:0]  m_data;
    logic [W-1:0]  exp_data;
    bit            exp_valid;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1 reset";
    bit    done     = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_sel_n = 1; m_data = '0;
            m_wl_n = 1; m_wh_n = 1; m_oe_n = 1;
            exp_data = '0; exp_valid = 0;
        end else begin
            exp_valid = 0;
            exp_data  = '0;
            if (!m_sel_n) begin
                if (!m_wl_n) ref_mem[m_addr][8:0]  = m_data[8:0];
                if (!m_wh_n) ref_mem[m_addr][17:9] = m_data[17:9];
                if (m_wl_n && m_wh_n && !m_oe_n) begin
                    exp_valid = 1;
                    exp_data  = ref_mem[m_addr];
                end
            end
            if (addr_le) begin
                m_addr  = int'(addr_in);
                m_sel_n = sel_n;
            end
            if (data_le) m_data = wr_data;
            m_wl_n = wr_lo_n;
            m_wh_n = wr_hi_n;
            m_oe_n = out_en_n;
        end
    end

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check(!rd_valid && rd_data == '0, "R1 reset outputs off",
                      {rd_valid, rd_data[16:0]}, '0);
            end else begin
                check(rd_valid == exp_valid, {phase, " (valid)"},
                      W'(rd_valid), W'(exp_valid));
                check(rd_data == exp_data, {phase, " (data)"}, rd_data, exp_data);
                if (!rd_valid)
                    check(rd_data == '0, "R11 bus zero when off", rd_data, '0);
            end
        end
    end

    task automatic drive(input bit ale, input bit dle, input int a, input bit s_n,
                         input bit wl, input bit wh, input bit oe, input logic [W-1:0] d);
        @(negedge clk);
        addr_le  = ale;
        data_le  = dle;
        addr_in  = AW'(a);
        sel_n    = s_n;
        wr_lo_n  = wl;
        wr_hi_n  = wh;
        out_en_n = oe;
        wr_data  = d;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R6 / R4: fill with both lanes, transparent capture
        phase = "R6 full-word write";
        for (int i = 0; i < DEPTH; i++)
            drive(1, 1, i, 0, 0, 0, 0, W'(i * 1031 + 7));
        phase = "R4 transparent read";
        for (int i = 0; i < DEPTH; i++)
            drive(1, 1, i, 0, 1, 1, 0, '1);

        // R5: single-lane writes
        phase = "R5 lower lane";
        for (int i = 0; i < 16; i++)
            drive(1, 1, i * 3, 0, 0, 1, 0, W'(18'h3_ffff - i));
        phase = "R5 upper lane";
        for (int i = 0; i < 16; i++)
            drive(1, 1, i * 5, 0, 1, 0, 1, W'(18'h1_2345 + i * 77));
        phase = "R5 lane readback";
        for (int i = 0; i < 80; i++)
            drive(1, 1, i, 0, 1, 1, 0, '0);

        // R2: address and select held while live inputs scramble
        phase = "R2 address hold";
        drive(1, 1, 42, 0, 1, 1, 0, '0);
        for (int i = 0; i < 6; i++)
            drive(0, 1, 200 - i, 1, 1, 1, 0, '0);
        phase = "R2 select hold high";
        drive(1, 1, 10, 1, 1, 1, 0, '0);
        for (int i = 0; i < 4; i++)
            drive(0, 1, 11, 0, 0, 0, 0, 18'h0_aaaa);

        // R3: data held across write
        phase = "R3 data hold";
        drive(1, 1, 77, 0, 1, 1, 1, 18'h2_5a5a);
        drive(1, 0, 77, 0, 0, 0, 1, 18'h1_1111);
        drive(1, 0, 78, 0, 0, 1, 1, 18'h0_0f0f);
        drive(1, 1, 77, 0, 1, 1, 0, '0);
        drive(1, 1, 78, 0, 1, 1, 0, '0);
        drive(1, 1, 78, 0, 1, 1, 0, '0);

        // R7: deselected writes leave memory untouched
        phase = "R7 deselect";
        for (int i = 0; i < 8; i++)
            drive(1, 1, i, 1, 0, 0, 0, 18'h3_c3c3);
        for (int i = 0; i < 8; i++)
            drive(1, 1, i, 0, 1, 1, 0, '0);

        // R9: output enable high
        phase = "R9 output enable off";
        for (int i = 0; i < 8; i++)
            drive(1, 1, i, 0, 1, 1, 1, '0);

        // R10: writes with output enable low
        phase = "R10 write forces off";
        for (int i = 0; i < 8; i++)
            drive(1, 1, 100 + i, 0, i[0], ~i[0], 0, W'(i * 4099));
        for (int i = 0; i < 8; i++)
            drive(1, 1, 100 + i, 0, 1, 1, 0, '0);

        // R8: random mix of everything
        phase = "R8 random mix";
        for (int i = 0; i < 3000; i++)
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                  $urandom_range(0, DEPTH - 1), $urandom_range(0, 5) == 0,
                  $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0,
                  $urandom_range(0, 4) == 0, W'($urandom));
        drive(1, 1, 0, 1, 1, 1, 1, '0);
        repeat (3) @(negedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule